// File: doc/BRIEF.md
# Bandwidth-Aware Prefetch Pattern Selector

This block sits beside a spatial prefetcher that learns two bit-patterns per signature: one biased toward coverage and one biased toward accuracy. It watches a pulse that marks each DRAM access and counts those pulses over a fixed measurement window, nominally four DRAM row-cycle times expressed in clock cycles. When a window closes, it compares the count with the largest number of accesses that window can carry and reduces the ratio to a quartile index. That index stays constant for the whole of the next window.

When a triggering access arrives with the two learned patterns and the saturation flags of their two quality counters, the block chooses which pattern to use, or none. Heavy bandwidth use favours the accuracy pattern or suppresses prefetching. Light use favours the coverage pattern. The chosen pattern is stored relative to the trigger. The block clears the trigger's own bit, rotates the pattern by the trigger's offset and presents it one cycle later.

Top module: `bw_pattern_selector`

## Requirements
- R1: While reset is held, and after it, until the first trigger or window end, `pf_valid_o`, `pf_src_o` and `pf_pat_o` are 0 and `bw_quart_o` is 0.
- R2: The measurement window is `WIN_CYC` clock cycles long and its first cycle is the first cycle after reset is released. `bw_quart_o` changes only at the clock edge that ends a window and holds its value at every other edge.
- R3: With `n` access pulses in a window and `P` = `PEAK_CNT`, the index becomes 3 if 4n ≥ 3P. Otherwise it becomes 2 if 4n ≥ 2P, otherwise 1 if 4n ≥ P, and otherwise 0. A count above `P` gives 3.
- R4: Each window starts counting from zero. Accesses in one window do not affect the index taken at the end of the next window.
- R5: The prefetch outputs are registered, so they reflect the trigger sampled at the previous edge. A cycle without a trigger gives `pf_valid_o`=0, `pf_src_o`=0 and `pf_pat_o`=0.
- R6: A trigger with `entry_hit_i`=0 gives no prefetch (`pf_valid_o`=0, `pf_src_o`=0), whatever the index and flags are.
- R7: At index 3, a trigger whose accuracy counter is saturated gives no prefetch. Otherwise the accuracy pattern is used (`pf_src_o`=2).
- R8: At index 2, the accuracy pattern is used (`pf_src_o`=2) if the coverage counter is saturated. Otherwise the coverage pattern is used (`pf_src_o`=1).
- R9: At index 0 or 1, the coverage pattern is used (`pf_src_o`=1) whatever the saturation flags are.
- R10: With `S` the selected pattern with bit 0 forced to 0 and `k` the trigger offset, `pf_pat_o[j]` = `S[(j+k) mod PAT_W]` for every `j`. `pf_valid_o` is 1 whenever a pattern is used, even if the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dram_acc_i | input | 1 | One DRAM access issued this cycle |
| trig_valid_i | input | 1 | Triggering access present this cycle |
| trig_off_i | input | OFF_W | Offset of the trigger within its region |
| entry_hit_i | input | 1 | Learned-pattern entry exists for the trigger |
| cov_pat_i | input | PAT_W | Coverage-biased pattern, anchored at the trigger |
| acc_pat_i | input | PAT_W | Accuracy-biased pattern, anchored at the trigger |
| cov_sat_i | input | 1 | Coverage quality counter saturated |
| acc_sat_i | input | 1 | Accuracy quality counter saturated |
| pf_valid_o | output | 1 | A pattern was selected for last cycle's trigger |
| pf_src_o | output | 2 | 0 none, 1 coverage pattern, 2 accuracy pattern |
| pf_pat_o | output | PAT_W | Selected pattern after masking and rotation |
| bw_quart_o | output | 2 | Latched utilization quartile index |

## Verification
Windows are filled with access counts that sit just below and exactly on each quartile boundary, plus one count above peak. These tell a `>` comparison apart from `≥` and catch a swapped threshold. A full window followed by a nearly empty one shows whether the count is cleared at each boundary. Triggers are applied at every index with all four combinations of saturation flags, and with a missing entry. This tells the two high-utilization rules apart from each other and from the low-utilization default. Patterns are given distinct coverage and accuracy values and several offsets, including zero and the largest offset, so that a wrong source, a wrong rotation direction or an unmasked trigger bit each show up in the output.

// File: rtl/bwsel_pkg.sv
// Package: shared encodings for the bandwidth-aware pattern selector.
// Assumes: quartile index is a plain 2-bit number, 0 = lowest utilization.
package bwsel_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_COV  = 2'd1,
        SRC_ACC  = 2'd2
    } pf_src_t;

    typedef logic [1:0] quart_t;
endpackage

// File: rtl/bw_window_meter.sv
// Module: bw_window_meter
// Counts DRAM access pulses over a window of WIN_CYC cycles and, at the
// edge ending each window, latches the quartile of count versus PEAK_CNT.
// Assumes: at most one access per cycle, WIN_CYC >= 2, PEAK_CNT >= 1.
module bw_window_meter
    import bwsel_pkg::*;
#(
    parameter int WIN_CYC  = 32,
    parameter int PEAK_CNT = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   acc_pulse,
    output quart_t quart
);
    localparam int WIN_W = $clog2(WIN_CYC);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam int CMP_W = CNT_W + 2 + $clog2(PEAK_CNT + 1);
    localparam logic [WIN_W-1:0] LAST_CYC = WIN_W'(WIN_CYC - 1);
    localparam logic [CMP_W-1:0] TH_Q1 = CMP_W'(PEAK_CNT);
    localparam logic [CMP_W-1:0] TH_Q2 = CMP_W'(2 * PEAK_CNT);
    localparam logic [CMP_W-1:0] TH_Q3 = CMP_W'(3 * PEAK_CNT);

    logic [WIN_W-1:0] win_pos;
    logic [CNT_W-1:0] hits;
    logic [CNT_W-1:0] hits_total;
    logic [CMP_W-1:0] scaled;
    quart_t           quart_nxt;
    logic             win_end;

    // Window end and final count including this cycle's pulse.
    always_comb begin
        win_end    = (win_pos == LAST_CYC);
        hits_total = hits + CNT_W'(acc_pulse);
        scaled     = CMP_W'(hits_total) << 2;
    end

    // Quartile decision from the scaled count.
    always_comb begin
        if (scaled >= TH_Q3)      quart_nxt = 2'd3;
        else if (scaled >= TH_Q2) quart_nxt = 2'd2;
        else if (scaled >= TH_Q1) quart_nxt = 2'd1;
        else                      quart_nxt = 2'd0;
    end

    // Window position, access count and latched quartile.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_pos <= '0;
            hits    <= '0;
            quart   <= 2'd0;
        end else if (win_end) begin
            win_pos <= '0;
            hits    <= '0;
            quart   <= quart_nxt;
        end else begin
            win_pos <= win_pos + 1'b1;
            hits    <= hits_total;
        end
    end
endmodule

// File: rtl/pattern_arbiter.sv
// Module: pattern_arbiter
// Chooses the pattern source for a trigger from the utilization quartile,
// the entry-hit flag and both quality-counter saturation flags.
// Assumes: purely combinational; caller registers the result.
module pattern_arbiter
    import bwsel_pkg::*;
(
    input  quart_t  quart,
    input  logic    hit,
    input  logic    cov_sat,
    input  logic    acc_sat,
    output pf_src_t src
);
    // Priority: miss, then quartile-specific rule.
    always_comb begin
        if (!hit) begin
            src = SRC_NONE;
        end else begin
            case (quart)
                2'd3:    src = acc_sat ? SRC_NONE : SRC_ACC;
                2'd2:    src = cov_sat ? SRC_ACC  : SRC_COV;
                default: src = SRC_COV;
            endcase
        end
    end
endmodule

// File: rtl/pattern_rotator.sv
// Module: pattern_rotator
// Clears the anchor (trigger) bit of a trigger-relative pattern and rotates
// it right by the trigger offset: out[j] = in[(j + off) mod PAT_W].
// Assumes: PAT_W is a power of two, so offset addition wraps naturally.
module pattern_rotator #(
    parameter int PAT_W = 16,
    localparam int OFF_W = $clog2(PAT_W)
) (
    input  logic [PAT_W-1:0] pat_in,
    input  logic [OFF_W-1:0] off,
    output logic [PAT_W-1:0] pat_out
);
    logic [PAT_W-1:0] masked;

    // Drop the trigger's own bit.
    always_comb begin
        masked    = pat_in;
        masked[0] = 1'b0;
    end

    // One selector per output bit.
    for (genvar j = 0; j < PAT_W; j++) begin : g_bit
        logic [OFF_W-1:0] src_idx;
        assign src_idx    = OFF_W'(j) + off;
        assign pat_out[j] = masked[src_idx];
    end
endmodule

// File: rtl/bw_pattern_selector.sv
// Module: bw_pattern_selector (top)
// Measures DRAM utilization per window and, per trigger, registers the
// selected learned pattern (masked and rotated) or no prefetch.
// Assumes: trigger inputs are valid in the cycle trig_valid_i is high.
module bw_pattern_selector
    import bwsel_pkg::*;
#(
    parameter int PAT_W    = 16,
    parameter int WIN_CYC  = 32,
    parameter int PEAK_CNT = 16,
    localparam int OFF_W   = $clog2(PAT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dram_acc_i,
    input  logic             trig_valid_i,
    input  logic [OFF_W-1:0] trig_off_i,
    input  logic             entry_hit_i,
    input  logic [PAT_W-1:0] cov_pat_i,
    input  logic [PAT_W-1:0] acc_pat_i,
    input  logic             cov_sat_i,
    input  logic             acc_sat_i,
    output logic             pf_valid_o,
    output logic [1:0]       pf_src_o,
    output logic [PAT_W-1:0] pf_pat_o,
    output logic [1:0]       bw_quart_o
);
    quart_t           quart;
    pf_src_t          src;
    logic [PAT_W-1:0] chosen;
    logic [PAT_W-1:0] rotated;

    bw_window_meter #(
        .WIN_CYC  (WIN_CYC),
        .PEAK_CNT (PEAK_CNT)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_pulse (dram_acc_i),
        .quart     (quart)
    );

    pattern_arbiter u_arb (
        .quart   (quart),
        .hit     (entry_hit_i),
        .cov_sat (cov_sat_i),
        .acc_sat (acc_sat_i),
        .src     (src)
    );

    // Pick the pattern named by the arbiter.
    always_comb begin
        case (src)
            SRC_COV: chosen = cov_pat_i;
            SRC_ACC: chosen = acc_pat_i;
            default: chosen = '0;
        endcase
    end

    pattern_rotator #(
        .PAT_W (PAT_W)
    ) u_rot (
        .pat_in  (chosen),
        .off     (trig_off_i),
        .pat_out (rotated)
    );

    // Register the prefetch decision for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !trig_valid_i) begin
            pf_valid_o <= 1'b0;
            pf_src_o   <= SRC_NONE;
            pf_pat_o   <= '0;
        end else begin
            pf_valid_o <= (src != SRC_NONE);
            pf_src_o   <= src;
            pf_pat_o   <= rotated;
        end
    end

    assign bw_quart_o = quart;
endmodule

// File: rtl/bw_pattern_selector_chk.sv
// Module: bw_pattern_selector_chk
// Port-level assertions for bw_pattern_selector, attached by bind.
// Assumes: keeps its own window position to know where the index may change.
module bw_pattern_selector_chk #(
    parameter int PAT_W   = 16,
    parameter int WIN_CYC = 32,
    localparam int OFF_W  = $clog2(PAT_W),
    localparam int WIN_W  = $clog2(WIN_CYC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_valid_i,
    input logic [OFF_W-1:0] trig_off_i,
    input logic             entry_hit_i,
    input logic             acc_sat_i,
    input logic             pf_valid_o,
    input logic [1:0]       pf_src_o,
    input logic [PAT_W-1:0] pf_pat_o,
    input logic [1:0]       bw_quart_o
);
    logic [WIN_W-1:0] pos;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] anchor_pos;

    // Independent window position and trigger offset copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            off_q <= '0;
        end else begin
            pos   <= (pos == WIN_W'(WIN_CYC - 1)) ? '0 : pos + 1'b1;
            off_q <= trig_off_i;
        end
    end

    assign anchor_pos = OFF_W'(0) - off_q;

    AST_QUART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != '0) |-> $stable(bw_quart_o)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_valid_i |=> (!pf_valid_o && pf_src_o == 2'd0)); // R5
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid_i && !entry_hit_i) |=> !pf_valid_o); // R6
    AST_HIGH_SAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid_i && entry_hit_i && bw_quart_o == 2'd3 && acc_sat_i)
        |=> !pf_valid_o); // R7
    AST_LOW_USES_COV: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid_i && entry_hit_i && bw_quart_o < 2'd2)
        |=> (pf_valid_o && pf_src_o == 2'd1)); // R9
    AST_ANCHOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid_o |-> !pf_pat_o[anchor_pos]); // R10
endmodule

bind bw_pattern_selector bw_pattern_selector_chk #(
    .PAT_W   (PAT_W),
    .WIN_CYC (WIN_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid_i (trig_valid_i),
    .trig_off_i   (trig_off_i),
    .entry_hit_i  (entry_hit_i),
    .acc_sat_i    (acc_sat_i),
    .pf_valid_o   (pf_valid_o),
    .pf_src_o     (pf_src_o),
    .pf_pat_o     (pf_pat_o),
    .bw_quart_o   (bw_quart_o)
);

// File: tb/bw_pattern_selector_bench.sv
// Directed bench for bw_pattern_selector.
module bw_pattern_selector_bench;
    localparam int PAT_W    = 16;
    localparam int WIN_CYC  = 32;
    localparam int PEAK_CNT = 16;
    localparam int OFF_W    = $clog2(PAT_W);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dram_acc_i = 1'b0;
    logic             trig_valid_i = 1'b0;
    logic [OFF_W-1:0] trig_off_i = '0;
    logic             entry_hit_i = 1'b0;
    logic [PAT_W-1:0] cov_pat_i = '0;
    logic [PAT_W-1:0] acc_pat_i = '0;
    logic             cov_sat_i = 1'b0;
    logic             acc_sat_i = 1'b0;
    logic             pf_valid_o;
    logic [1:0]       pf_src_o;
    logic [PAT_W-1:0] pf_pat_o;
    logic [1:0]       bw_quart_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bw_pattern_selector #(
        .PAT_W (PAT_W), .WIN_CYC (WIN_CYC), .PEAK_CNT (PEAK_CNT)
    ) u_bw_pattern_selector (
        .clk (clk), .rst_n (rst_n), .dram_acc_i (dram_acc_i),
        .trig_valid_i (trig_valid_i), .trig_off_i (trig_off_i),
        .entry_hit_i (entry_hit_i), .cov_pat_i (cov_pat_i),
        .acc_pat_i (acc_pat_i), .cov_sat_i (cov_sat_i),
        .acc_sat_i (acc_sat_i), .pf_valid_o (pf_valid_o),
        .pf_src_o (pf_src_o), .pf_pat_o (pf_pat_o),
        .bw_quart_o (bw_quart_o)
    );

    function automatic logic [PAT_W-1:0] ref_rot(logic [PAT_W-1:0] p,
                                                  int k);
        logic [PAT_W-1:0] r;
        p[0] = 1'b0;
        for (int j = 0; j < PAT_W; j++) r[j] = p[(j + k) % PAT_W];
        return r;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reset, starting at a negedge, released at a negedge.
    task automatic do_reset();
        rst_n = 1'b0; dram_acc_i = 1'b0; trig_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 quart in reset", bw_quart_o, 0);
        check("R1 valid in reset", pf_valid_o, 0);
        rst_n = 1'b1;
    endtask

    // Drive n pulses in one full window; ends at negedge after window edge.
    task automatic run_window(int n);
        for (int i = 0; i < WIN_CYC; i++) begin
            dram_acc_i = (i < n);
            @(negedge clk);
        end
        dram_acc_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R1 quart", bw_quart_o, 0);
        check("R1 valid", pf_valid_o, 0);
        check("R1 src", pf_src_o, 0);
        check("R1 pat", pf_pat_o, 0);
    endtask

    task automatic t_quart(int n, int exp);
        do_reset();
        run_window(n);
        check($sformatf("R3 quart n=%0d", n), bw_quart_o, exp);
    endtask

    task automatic t_hold_and_restart();
        do_reset();
        run_window(12);
        check("R2 quart after full window", bw_quart_o, 3);
        for (int i = 0; i < WIN_CYC - 1; i++) begin
            dram_acc_i = (i < 2);
            @(negedge clk);
        end
        check("R2 quart held mid window", bw_quart_o, 3);
        @(negedge clk);
        check("R4 quart after sparse window", bw_quart_o, 0);
    endtask

    // One trigger; result checked at following negedge.
    task automatic trig(bit hit, bit cs, bit as, logic [PAT_W-1:0] cp,
                        logic [PAT_W-1:0] ap, int k, int exp_src,
                        string req);
        logic [PAT_W-1:0] exp_pat;
        trig_valid_i = 1'b1; entry_hit_i = hit; cov_sat_i = cs;
        acc_sat_i = as; cov_pat_i = cp; acc_pat_i = ap;
        trig_off_i = OFF_W'(k);
        @(negedge clk);
        trig_valid_i = 1'b0;
        exp_pat = (exp_src == 1) ? ref_rot(cp, k) :
                  (exp_src == 2) ? ref_rot(ap, k) : '0;
        check({req, " valid"}, pf_valid_o, exp_src != 0);
        check({req, " src"}, pf_src_o, exp_src);
        check({req, " pat"}, pf_pat_o, exp_pat);
    endtask

    task automatic t_select(int n, int q);
        logic [PAT_W-1:0] cp = 16'hA5C3;
        logic [PAT_W-1:0] ap = 16'h0181;
        int               e[4];
        do_reset();
        run_window(n);
        check("R3 setup quart", bw_quart_o, q);
        // e index = {cov_sat, acc_sat}
        if (q == 3)      e = '{2, 0, 2, 0};
        else if (q == 2) e = '{1, 1, 2, 2};
        else             e = '{1, 1, 1, 1};
        for (int f = 0; f < 4; f++)
            trig(1'b1, f[1], f[0], cp, ap, 3 + f, e[f],
                 (q == 3) ? "R7" : (q == 2) ? "R8" : "R9");
        trig(1'b0, 1'b0, 1'b0, cp, ap, 1, 0, "R6 miss");
        @(negedge clk);
        check("R5 idle valid", pf_valid_o, 0);
        check("R5 idle pat", pf_pat_o, 0);
    endtask

    task automatic t_rotate();
        do_reset();
        trig(1'b1, 1'b0, 1'b0, 16'h8003, 16'h0, 0, 1, "R10 off0");
        trig(1'b1, 1'b0, 1'b0, 16'h8003, 16'h0, 15, 1, "R10 off15");
        trig(1'b1, 1'b0, 1'b0, 16'h0012, 16'h0, 4, 1, "R10 off4");
        trig(1'b1, 1'b1, 1'b1, 16'h0001, 16'h0, 7, 1, "R10 anchor only");
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_quart(3, 0);
        t_quart(4, 1);
        t_quart(7, 1);
        t_quart(8, 2);
        t_quart(11, 2);
        t_quart(12, 3);
        t_quart(20, 3);
        t_hold_and_restart();
        t_select(12, 3);
        t_select(8, 2);
        t_select(4, 1);
        t_select(0, 0);
        t_rotate();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule